// File: doc/BRIEF.md
# Bit-serial HDLC frame receiver with tagged byte queue

This block takes a serial bit stream, qualified by a one-cycle strobe per bit, and recovers HDLC frames from it. It looks for the opening flag, strips the zero bits that a transmitter stuffs after five ones, and checks the frame check sequence and the byte alignment at the closing flag. It can also reject frames by their first (address) byte. Every byte it accepts goes into a receive queue with a 2-bit tag. The tag tells a reader whether the byte opens a frame, sits inside one, or closes one, and whether a closing frame was good or bad.

The two FCS bytes never reach the queue. A three-byte hold stage sits ahead of the queue and keeps the newest bytes back until the closing flag decides what they are. A separate monitor watches the raw line for a run of 15 ones and reports an idle channel. It raises a validity flag once the indication can be trusted. Disabling the receiver takes effect at once between frames, but a frame that is partly received is completed first.

Top module: `hdlc_rx_top`

## Requirements
- R1: After reset the queue is empty (`rd_empty`=1), and `idle_chan` and `idle_valid` are both 0.
- R2: A zero that follows five consecutive ones is removed. Payload bytes such as 8'hFF and 8'h7E come out of the queue unchanged.
- R3: Each queue entry reads as `{rd_status, rd_data}`. `rd_status` is 2'b01 on the first byte of a frame, 2'b00 on the bytes inside it, and 2'b10 on the last byte of a good frame. The last byte is the address byte itself when a frame has no data. The two FCS bytes are never stored. `rd_data` shows the oldest entry, and a cycle with `rd_en` removes it.
- R4: A frame whose CRC-16 (reflected polynomial 16'h8408, preset 16'hFFFF, taken over the address, data and FCS bytes, each sent LSB first) does not leave the residue 16'hF0B8 stores its last byte with status 2'b11.
- R5: Seven or more consecutive ones abort the frame. Of the n whole bytes received before the abort, the first n-2 are stored when n ≥ 3, and the last of them carries status 2'b11.
- R6: A frame whose bit count between the flags is not a multiple of 8 has its last byte stored with status 2'b11.
- R7: A frame with fewer than three bytes between its flags stores nothing.
- R8: While `addr_filter_en` is 1, a frame is stored only if its first byte equals `station_addr` or 8'hFF. While it is 0, every frame is stored.
- R9: While `rx_enable` is 0 and no frame is in progress, line bits are ignored and nothing is stored. Setting `rx_enable` starts the flag search on the next bit.
- R10: Clearing `rx_enable` after a frame's first byte lets that frame complete and be stored. The frames that follow are ignored.
- R11: `idle_chan` is 1 once the last 15 or more line bits were all ones, and returns to 0 on the next zero.
- R12: `idle_valid` stays 0 until 15 bits have been seen or one zero has been seen, and then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line data |
| rx_enable | input | 1 | Receiver enable |
| addr_filter_en | input | 1 | Enables address filtering |
| station_addr | input | 8 | Address the station answers to |
| rd_en | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Oldest queue entry, data byte |
| rd_status | output | 2 | Oldest queue entry, position/validity tag |
| rd_empty | output | 1 | Queue holds no entry |
| idle_chan | output | 1 | 15 or more ones seen in a row |
| idle_valid | output | 1 | Idle indication is meaningful |

## Verification
The checker assumes that `rx_enable`, `addr_filter_en` and `station_addr` are changed only between line bits. It also assumes that a tagged byte can be written only as a result of a line bit that arrived while the receiver was active. The bench holds every control input steady while a byte is on the line. It changes `rx_enable` only after whole bytes, and drains the queue after every frame so that the queue never fills. Stimulus bits are stuffed by a model inside the bench. Flags, aborts and stray alignment bits are inserted without stuffing, so every special pattern reaches the design exactly as intended.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int FCS_BYTES = 2;
    localparam int HOLD_D    = FCS_BYTES + 1;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;
    localparam logic [BYTE_W-1:0] ALL_CALL = 8'hFF;

    typedef enum logic [1:0] {
        ST_MID      = 2'b00,
        ST_FIRST    = 2'b01,
        ST_LAST_OK  = 2'b10,
        ST_LAST_BAD = 2'b11
    } byte_stat_e;

    typedef struct packed {
        byte_stat_e        stat;
        logic [BYTE_W-1:0] data;
    } q_word_t;

    typedef struct packed {
        logic              byte_vld;
        logic              flag;
        logic              abort;
        logic              aligned;
        logic [BYTE_W-1:0] data;
    } line_evt_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [BYTE_W-1:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
    import hdlc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      bit_en,
    input  logic      bit_in,
    output line_evt_t evt
);
    localparam int NB_W = $clog2(BYTE_W);

    logic [2:0]        ones_q;
    logic [BYTE_W-1:0] sr_q;
    logic [NB_W-1:0]   nbits_q;
    line_evt_t         evt_q;
    logic [BYTE_W-1:0] sr_next;
    logic              keep_bit;

    assign sr_next  = {bit_in, sr_q[BYTE_W-1:1]};
    // a one is data while the run stays at five or fewer; a zero is data unless it is a stuff or flag end
    assign keep_bit = bit_in ? (ones_q < 3'd5) : (ones_q != 3'd5 && ones_q != 3'd6);

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q  <= '0;
            sr_q    <= '0;
            nbits_q <= '0;
            evt_q   <= '0;
        end else begin
            evt_q <= '0;
            if (clr) begin
                ones_q  <= '0;
                nbits_q <= '0;
            end else if (bit_en) begin
                if (bit_in) begin
                    if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
                    if (ones_q == 3'd6) evt_q.abort <= 1'b1;
                end else begin
                    ones_q <= '0;
                end
                if (!bit_in && ones_q == 3'd6) begin
                    evt_q.flag    <= 1'b1;
                    // flag contributes its zero and five ones as data bits
                    evt_q.aligned <= (nbits_q == NB_W'(6));
                    nbits_q       <= '0;
                end else if (keep_bit) begin
                    sr_q    <= sr_next;
                    nbits_q <= nbits_q + 1'b1;
                    if (nbits_q == NB_W'(BYTE_W - 1)) begin
                        evt_q.byte_vld <= 1'b1;
                        evt_q.data     <= sr_next;
                    end
                end
            end
        end
    end

    assign evt = evt_q;
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  line_evt_t         evt,
    input  logic              addr_en,
    input  logic [BYTE_W-1:0] station,
    output logic              wr_en,
    output q_word_t           wr_word,
    output logic              busy
);
    localparam int CNT_W = $clog2(HOLD_D + 1);

    logic              in_frame_q;
    logic              wrote_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [15:0]       crc_q;
    logic [BYTE_W-1:0] hold_q [HOLD_D];
    logic              hold_full;
    logic              addr_reject;
    byte_stat_e        close_stat;

    assign hold_full   = (cnt_q == CNT_W'(HOLD_D));
    assign addr_reject = addr_en && (evt.data != station) && (evt.data != ALL_CALL);
    assign close_stat  = (evt.aligned && crc_q == CRC_RESIDUE) ? ST_LAST_OK : ST_LAST_BAD;
    assign busy        = in_frame_q && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            wrote_q    <= 1'b0;
            cnt_q      <= '0;
            crc_q      <= CRC_PRESET;
            wr_en      <= 1'b0;
            wr_word    <= '0;
            for (int i = 0; i < HOLD_D; i++) hold_q[i] <= '0;
        end else begin
            wr_en <= 1'b0;
            if (clr) begin
                in_frame_q <= 1'b0;
                cnt_q      <= '0;
            end else if (evt.abort && in_frame_q) begin
                if (hold_full) begin
                    wr_en   <= 1'b1;
                    wr_word <= '{stat: ST_LAST_BAD, data: hold_q[HOLD_D-1]};
                end
                in_frame_q <= 1'b0;
                cnt_q      <= '0;
            end else if (evt.flag) begin
                if (in_frame_q && hold_full) begin
                    wr_en   <= 1'b1;
                    wr_word <= '{stat: close_stat, data: hold_q[HOLD_D-1]};
                end
                in_frame_q <= 1'b1;
                cnt_q      <= '0;
                crc_q      <= CRC_PRESET;
                wrote_q    <= 1'b0;
            end else if (evt.byte_vld && in_frame_q) begin
                if (cnt_q == '0 && addr_reject) begin
                    in_frame_q <= 1'b0;
                end else begin
                    crc_q     <= crc_step(crc_q, evt.data);
                    hold_q[0] <= evt.data;
                    for (int i = 1; i < HOLD_D; i++) hold_q[i] <= hold_q[i-1];
                    if (!hold_full) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else begin
                        wr_en   <= 1'b1;
                        wr_word <= '{stat: (wrote_q ? ST_MID : ST_FIRST), data: hold_q[HOLD_D-1]};
                        wrote_q <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  q_word_t wr_word,
    input  logic    rd_en,
    output q_word_t rd_word,
    output logic    empty
);
    localparam int AW = $clog2(DEPTH);

    q_word_t       mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_wr, do_rd;

    assign do_wr   = wr_en && (cnt_q != (AW+1)'(DEPTH));
    assign do_rd   = rd_en && (cnt_q != '0);
    assign empty   = (cnt_q == '0);
    assign rd_word = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= wp_q + 1'b1;
            if (do_rd) rp_q <= rp_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/hdlc_idle_mon.sv
module hdlc_idle_mon #(
    parameter int RUN = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic idle_chan,
    output logic idle_valid
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] run_q, seen_q;
    logic          zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            seen_q <= '0;
            zero_q <= 1'b0;
        end else if (bit_valid) begin
            if (seen_q != CW'(RUN)) seen_q <= seen_q + 1'b1;
            if (bit_in) begin
                if (run_q != CW'(RUN)) run_q <= run_q + 1'b1;
            end else begin
                run_q  <= '0;
                zero_q <= 1'b1;
            end
        end
    end

    assign idle_chan  = (run_q == CW'(RUN));
    assign idle_valid = zero_q || (seen_q == CW'(RUN));
endmodule

// File: rtl/hdlc_rx_top.sv
module hdlc_rx_top
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int IDLE_RUN   = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       rx_enable,
    input  logic       addr_filter_en,
    input  logic [7:0] station_addr,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic [1:0] rd_status,
    output logic       rd_empty,
    output logic       idle_chan,
    output logic       idle_valid
);
    line_evt_t evt;
    q_word_t   wr_word, rd_word;
    logic      wr_en, busy, active;

    assign active = rx_enable || busy;

    hdlc_rx_deframe u_deframe (
        .clk(clk), .rst(rst), .clr(!active),
        .bit_en(bit_valid && active), .bit_in(bit_in), .evt(evt)
    );

    hdlc_rx_frame u_frame (
        .clk(clk), .rst(rst), .clr(!active), .evt(evt),
        .addr_en(addr_filter_en), .station(station_addr),
        .wr_en(wr_en), .wr_word(wr_word), .busy(busy)
    );

    hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .rd_en(rd_en), .rd_word(rd_word), .empty(rd_empty)
    );

    hdlc_idle_mon #(.RUN(IDLE_RUN)) u_idle (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .idle_chan(idle_chan), .idle_valid(idle_valid)
    );

    assign rd_data   = rd_word.data;
    assign rd_status = rd_word.stat;
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk
    import hdlc_rx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bit_valid,
    input logic      rx_enable,
    input logic      busy,
    input line_evt_t evt,
    input logic      wr_en,
    input q_word_t   wr_word,
    input logic      idle_chan,
    input logic      idle_valid
);
    logic open_q;
    logic any_evt;

    assign any_evt = evt.byte_vld || evt.flag || evt.abort;

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else if (wr_en) open_q <= (wr_word.stat == ST_FIRST || wr_word.stat == ST_MID);
    end

    AST_IDLE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        idle_chan |-> idle_valid); // R11
    AST_IDLE_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        idle_valid |=> idle_valid); // R12
    AST_EVT_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
        any_evt |-> $past(bit_valid)); // R2
    AST_WRITE_FROM_EVT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(any_evt)); // R3
    AST_MID_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word.stat == ST_MID) |-> open_q); // R3
    AST_FIRST_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word.stat == ST_FIRST) |-> !open_q); // R3
    AST_WRITE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rx_enable || busy, 2)); // R9
endmodule

bind hdlc_rx_top hdlc_rx_chk u_chk (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_enable(rx_enable),
    .busy(busy), .evt(evt), .wr_en(wr_en), .wr_word(wr_word),
    .idle_chan(idle_chan), .idle_valid(idle_valid)
);

// File: tb/tb_hdlc_rx_top.sv
module tb_hdlc_rx_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_valid = 1'b0, bit_in = 1'b0;
    logic       rx_enable = 1'b1, addr_filter_en = 1'b0;
    logic [7:0] station_addr = 8'h5A;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] rd_status;
    logic       rd_empty, idle_chan, idle_valid;

    int nchk = 0, nfail = 0;
    bit done = 0;
    int tx_ones = 0;
    int drop_at = -1;
    logic [7:0] pl [0:15];
    logic [9:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_top dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .rx_enable(rx_enable), .addr_filter_en(addr_filter_en),
        .station_addr(station_addr), .rd_en(rd_en), .rd_data(rd_data),
        .rd_status(rd_status), .rd_empty(rd_empty), .idle_chan(idle_chan),
        .idle_valid(idle_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic send_bit(input logic b);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        bit_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_dbit(input logic b);
        send_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
        end else tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        repeat (6) send_bit(1'b1);
        send_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic send_frame(input int n, input bit bad_fcs, input int extra, input bit abort_it);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        send_flag();
        for (int i = 0; i < n; i++) begin
            c = ref_crc(c, pl[i]);
            send_byte(pl[i]);
            if (i == drop_at) rx_enable = 1'b0;
        end
        if (abort_it) begin
            repeat (8) send_bit(1'b1);
            idle(10);
            return;
        end
        fcs = ~c;
        if (bad_fcs) fcs[0] = ~fcs[0];
        send_byte(fcs[7:0]);
        send_byte(fcs[15:8]);
        for (int i = 0; i < extra; i++) send_dbit(1'b0);
        send_flag();
        idle(10);
    endtask

    task automatic expect_frame(input int n, input bit good);
        for (int i = 0; i < n; i++) begin
            logic [1:0] st;
            if (i == n - 1) st = good ? 2'b10 : 2'b11;
            else            st = (i == 0) ? 2'b01 : 2'b00;
            exp_q.push_back({st, pl[i]});
        end
    endtask

    task automatic drain(input string req);
        while (rd_empty == 1'b0) begin
            logic [31:0] e = (exp_q.size() > 0) ? {22'b0, exp_q.pop_front()} : 32'hDEAD;
            chk(req, {22'b0, rd_status, rd_data}, e);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) pl[i] = 8'((i * 53) + (seed * 17) + 8'h7E);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 empty", rd_empty, 1);
        chk("R1 idle_chan", idle_chan, 0);
        chk("R1 idle_valid", idle_valid, 0);

        // idle monitor: validity after 15 bits, run of 15 ones
        repeat (14) send_bit(1'b1);
        chk("R12 not yet valid", idle_valid, 0);
        chk("R11 run of 14", idle_chan, 0);
        send_bit(1'b1);
        chk("R12 valid at 15", idle_valid, 1);
        chk("R11 run of 15", idle_chan, 1);
        send_bit(1'b0);
        chk("R11 cleared by zero", idle_chan, 0);
        chk("R12 stays valid", idle_valid, 1);
        idle(2);
        do_reset();
        send_bit(1'b0);
        chk("R12 valid on first zero", idle_valid, 1);
        chk("R11 no run", idle_chan, 0);
        idle(2);

        // good frames over a sweep of lengths
        for (int n = 1; n <= 12; n++) begin
            fill(n, n);
            send_frame(n, 0, 0, 0);
            expect_frame(n, 1);
            drain("R3 good frame");
        end

        // patterns forcing zero insertion
        pl[0] = 8'hFF; pl[1] = 8'h7E; pl[2] = 8'hFC; pl[3] = 8'h3F; pl[4] = 8'h1F; pl[5] = 8'hFF;
        send_frame(6, 0, 0, 0);
        expect_frame(6, 1);
        drain("R2 stuffed payload");

        // corrupted check sequence
        for (int n = 1; n <= 6; n++) begin
            fill(n, n + 40);
            send_frame(n, 1, 0, 0);
            expect_frame(n, 0);
            drain("R4 bad fcs");
        end

        // too short: only two bytes between flags
        fill(2, 3);
        send_frame(0, 0, 0, 0);
        drain("R7 short frame");

        // abort after n whole bytes
        for (int n = 3; n <= 7; n++) begin
            fill(n, n + 80);
            send_frame(n, 0, 0, 1);
            expect_frame(n - 2, 0);
            drain("R5 abort");
        end
        fill(2, 9);
        send_frame(2, 0, 0, 1);
        drain("R5 abort short");

        // one stray bit before the closing flag
        for (int n = 2; n <= 5; n += 3) begin
            fill(n, n + 7);
            send_frame(n, 0, 1, 0);
            expect_frame(n, 0);
            drain("R6 misaligned");
        end

        // address filter sweep
        addr_filter_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] a;
            case (k)
                0: a = 8'h00; 1: a = 8'h5A; 2: a = 8'hFF;
                3: a = 8'hA5; 4: a = 8'h5B; default: a = 8'hDA;
            endcase
            fill(4, k);
            pl[0] = a;
            send_frame(4, 0, 0, 0);
            if (a == 8'h5A || a == 8'hFF) expect_frame(4, 1);
            drain("R8 filter on");
        end
        addr_filter_en = 1'b0;
        fill(4, 21);
        pl[0] = 8'h33;
        send_frame(4, 0, 0, 0);
        expect_frame(4, 1);
        drain("R8 filter off");

        // disabled receiver ignores frames; enabling is immediate
        rx_enable = 1'b0;
        fill(5, 2);
        send_frame(5, 0, 0, 0);
        drain("R9 disabled");
        rx_enable = 1'b1;
        fill(5, 4);
        send_frame(5, 0, 0, 0);
        expect_frame(5, 1);
        drain("R9 enabled");

        // disable mid-frame: frame completes, later frames ignored
        fill(6, 11);
        drop_at = 2;
        send_frame(6, 0, 0, 0);
        drop_at = -1;
        expect_frame(6, 1);
        drain("R10 finish frame");
        chk("R10 enable low", rx_enable, 0);
        fill(6, 12);
        send_frame(6, 0, 0, 0);
        drain("R10 after disable");
        rx_enable = 1'b1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule